// File: doc/BRIEF.md
# Break Input Digital Filter

This block removes short glitches from one break (fault) input before the signal reaches the output-protection logic of a motor-control timer. A 4-bit filter code picks two things at once: the rate at which the input is sampled and how many consecutive samples must all show a new level before the filtered output takes that level. The sampling rate is either every kernel clock cycle or a fraction (1/2 to 1/32) of a dead-time clock. The dead-time clock is supplied as a one-cycle tick enable in the kernel clock domain. The sample counts do not follow a regular pattern, so the block decodes the code through a table.

Code zero turns the filter off. The raw input then drives the output through a purely combinational path, so a fault is seen without any sampling delay. The block expects its input to be synchronised already. It contains the prescaler that makes the sampling strobe and the run counter that counts matching samples. When the code changes, both restart from zero, so a count built up under the old setting never carries into the new one.

Top module: `brk_filter`

## Requirements
- R1: With a nonzero code, the filtered output takes a new level only on the N-th consecutive sample that shows that level, where N is the count selected by the code.
- R2: With code 0, the output equals the raw input combinationally, with no clock edge needed.
- R3: Codes 1, 2 and 3 sample on every kernel clock cycle, with N equal to 2, 4 and 8 respectively.
- R4: Codes 4 and 5 sample on every 2nd dead-time tick, codes 6 and 7 on every 4th, and codes 8 and 9 on every 8th. Even codes in this range use N=6 and odd codes use N=8.
- R5: Codes 10, 11 and 12 sample on every 16th dead-time tick, and codes 13, 14 and 15 on every 32nd. The three codes of each group use N=5, 6 and 8 in ascending code order.
- R6: A sample equal to the current output level clears the count of consecutive differing samples.
- R7: While reset is held, and right after it, the filtered output is 0 (inactive) and the prescaler and counter are zero.
- R8: In the cycle the code changes, the prescaler and counter return to zero and no sample is taken. Counting restarts on the next cycle.
- R9: For codes 4 to 15, no sample is taken in a cycle without a dead-time tick, so a long input change with no ticks leaves the output unchanged.
- R10: While code 0 is selected, the held filter level tracks the raw input. After a switch to a filtering code, the output therefore starts at the level the raw input had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dts_tick_i | input | 1 | One-cycle enable marking each dead-time clock period |
| brk_raw_i | input | 1 | Synchronised raw break level, 1 = active |
| code_i | input | 4 | Filter code, 0 = pass-through, 1..15 = rate and count selection |
| brk_filt_o | output | 1 | Filtered break level |

## Verification
The case that is hardest to reach from the ports is the exact cycle in which the slowest settings change the output. With a divide-by-32 prescaler, the strobe phase is free-running and cannot be seen from outside. The bench removes that unknown by changing the code together with the input step, which forces the prescaler and counter back to zero. From that point the edge at which the output moves is exactly N times the divider. The bench checks this for every code and in both directions, on the cycle just before the change and on the cycle of the change. It also holds the tick low to show that no sampling happens, and it switches the code partway through a count to show that the count restarts.

// File: rtl/brk_filt_pkg.sv
package brk_filt_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 4;
  localparam int DIVL_W = 3;
  localparam int PSC_W  = 5;

  typedef struct packed {
    logic              bypass;
    logic              kernel;
    logic [DIVL_W-1:0] div_log2;
    logic [CNT_W-1:0]  n_req;
  } filt_cfg_t;
endpackage

// File: rtl/brk_filt_decode.sv
module brk_filt_decode
  import brk_filt_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output filt_cfg_t         cfg_o
);
  always_comb begin
    cfg_o.bypass   = (code_i == '0);
    cfg_o.kernel   = (code_i <= CODE_W'(3));
    cfg_o.div_log2 = '0;
    cfg_o.n_req    = CNT_W'(1);
    unique case (code_i)
      4'd0:  cfg_o.n_req = CNT_W'(1);
      4'd1:  cfg_o.n_req = CNT_W'(2);
      4'd2:  cfg_o.n_req = CNT_W'(4);
      4'd3:  cfg_o.n_req = CNT_W'(8);
      4'd4:  begin cfg_o.div_log2 = DIVL_W'(1); cfg_o.n_req = CNT_W'(6); end
      4'd5:  begin cfg_o.div_log2 = DIVL_W'(1); cfg_o.n_req = CNT_W'(8); end
      4'd6:  begin cfg_o.div_log2 = DIVL_W'(2); cfg_o.n_req = CNT_W'(6); end
      4'd7:  begin cfg_o.div_log2 = DIVL_W'(2); cfg_o.n_req = CNT_W'(8); end
      4'd8:  begin cfg_o.div_log2 = DIVL_W'(3); cfg_o.n_req = CNT_W'(6); end
      4'd9:  begin cfg_o.div_log2 = DIVL_W'(3); cfg_o.n_req = CNT_W'(8); end
      4'd10: begin cfg_o.div_log2 = DIVL_W'(4); cfg_o.n_req = CNT_W'(5); end
      4'd11: begin cfg_o.div_log2 = DIVL_W'(4); cfg_o.n_req = CNT_W'(6); end
      4'd12: begin cfg_o.div_log2 = DIVL_W'(4); cfg_o.n_req = CNT_W'(8); end
      4'd13: begin cfg_o.div_log2 = DIVL_W'(5); cfg_o.n_req = CNT_W'(5); end
      4'd14: begin cfg_o.div_log2 = DIVL_W'(5); cfg_o.n_req = CNT_W'(6); end
      default: begin cfg_o.div_log2 = DIVL_W'(5); cfg_o.n_req = CNT_W'(8); end
    endcase
  end
endmodule

// File: rtl/brk_filt_prescale.sv
module brk_filt_prescale
  import brk_filt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              bypass_i,
  input  logic              kernel_i,
  input  logic [DIVL_W-1:0] div_log2_i,
  output logic              strobe_o,
  output logic [PSC_W-1:0]  psc_o
);
  logic [PSC_W-1:0] psc_q, psc_d, term;
  logic             hold_zero;

  assign term      = (PSC_W'(1) << div_log2_i) - PSC_W'(1);
  assign hold_zero = restart_i | bypass_i | kernel_i;

  always_comb begin
    psc_d = psc_q;
    if (hold_zero)          psc_d = '0;
    else if (tick_i)        psc_d = (psc_q == term) ? '0 : psc_q + PSC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_d;
  end

  always_comb begin
    strobe_o = 1'b0;
    if (!restart_i && !bypass_i)
      strobe_o = kernel_i | (tick_i & (psc_q == term));
  end

  assign psc_o = psc_q;
endmodule

// File: rtl/brk_filt_run.sv
module brk_filt_run
  import brk_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic             strobe_i,
  input  logic             restart_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] n_req_i,
  output logic             level_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             level_q, level_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    if (bypass_i) begin
      level_d = raw_i;
      cnt_d   = '0;
    end else if (restart_i) begin
      cnt_d   = '0;
    end else if (strobe_i) begin
      if (raw_i == level_q) begin
        cnt_d = '0;
      end else if (cnt_inc >= {1'b0, n_req_i}) begin
        level_d = raw_i;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = level_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/brk_filter.sv
module brk_filter
  import brk_filt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dts_tick_i,
  input  logic              brk_raw_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              brk_filt_o
);
  logic              rst_meta_q, rst_n;
  logic [CODE_W-1:0] code_q;
  logic              cfg_restart;
  filt_cfg_t         cfg;
  logic              sample_stb;
  logic [PSC_W-1:0]  psc_cnt;
  logic [CNT_W-1:0]  run_cnt;
  logic              held_level;
  logic              bypass, kernel_rate;
  logic [CNT_W-1:0]  need_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_i;
  end

  assign cfg_restart = (code_i != code_q);

  brk_filt_decode u_dec (
    .code_i (code_i),
    .cfg_o  (cfg)
  );

  assign bypass      = cfg.bypass;
  assign kernel_rate = cfg.kernel;
  assign need_cnt    = cfg.n_req;

  brk_filt_prescale u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .tick_i     (dts_tick_i),
    .restart_i  (cfg_restart),
    .bypass_i   (bypass),
    .kernel_i   (kernel_rate),
    .div_log2_i (cfg.div_log2),
    .strobe_o   (sample_stb),
    .psc_o      (psc_cnt)
  );

  brk_filt_run u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .raw_i     (brk_raw_i),
    .strobe_i  (sample_stb),
    .restart_i (cfg_restart),
    .bypass_i  (bypass),
    .n_req_i   (need_cnt),
    .level_o   (held_level),
    .cnt_o     (run_cnt)
  );

  assign brk_filt_o = bypass ? brk_raw_i : held_level;
endmodule

// File: rtl/brk_filter_chk.sv
module brk_filter_chk
  import brk_filt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_n,
  input logic              dts_tick_i,
  input logic              brk_raw_i,
  input logic [CODE_W-1:0] code_i,
  input logic              brk_filt_o,
  input logic              cfg_restart,
  input logic              sample_stb,
  input logic [PSC_W-1:0]  psc_cnt,
  input logic [CNT_W-1:0]  run_cnt,
  input logic              held_level,
  input logic              bypass,
  input logic              kernel_rate,
  input logic [CNT_W-1:0]  need_cnt
);
  AST_BYPASS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (code_i == '0) |-> (brk_filt_o == brk_raw_i)); // R2

  AST_LEVEL_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!bypass && !cfg_restart) |=> ((held_level == $past(held_level)) || $past(sample_stb))); // R1

  AST_CNT_BELOW_N: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!bypass && !cfg_restart) |-> (run_cnt < need_cnt)); // R1

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_restart |=> (run_cnt == '0 && psc_cnt == '0)); // R8

  AST_KERNEL_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (kernel_rate && !bypass && !cfg_restart) |-> sample_stb); // R3

  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sample_stb && !kernel_rate) |-> dts_tick_i); // R9

  AST_RESET_STATE: assert property (@(posedge clk_i)
    (rst_n && !$past(rst_n)) |-> (held_level == 1'b0 && run_cnt == '0 && psc_cnt == '0)); // R7
endmodule

bind brk_filter brk_filter_chk u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .dts_tick_i  (dts_tick_i),
  .brk_raw_i   (brk_raw_i),
  .code_i      (code_i),
  .brk_filt_o  (brk_filt_o),
  .cfg_restart (cfg_restart),
  .sample_stb  (sample_stb),
  .psc_cnt     (psc_cnt),
  .run_cnt     (run_cnt),
  .held_level  (held_level),
  .bypass      (bypass),
  .kernel_rate (kernel_rate),
  .need_cnt    (need_cnt)
);

// File: tb/brk_filter_test.sv
module brk_filter_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       dts_tick_i;
  logic       brk_raw_i;
  logic [3:0] code_i;
  logic       brk_filt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  brk_filter uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dts_tick_i (dts_tick_i),
    .brk_raw_i  (brk_raw_i),
    .code_i     (code_i),
    .brk_filt_o (brk_filt_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int div_of(input int c);
    if (c <= 3)       return 1;
    else if (c <= 9)  return 1 << ((c - 2) / 2);
    else if (c <= 12) return 16;
    else              return 32;
  endfunction

  function automatic int n_of(input int c);
    if (c <= 3)       return 2 << (c - 1);
    else if (c <= 9)  return (c % 2 == 0) ? 6 : 8;
    else begin
      case ((c - 10) % 3)
        0:       return 5;
        1:       return 6;
        default: return 8;
      endcase
    end
  endfunction

  task automatic edges(input int k);
    repeat (k) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // preload held level through pass-through mode
  task automatic preload(input logic lvl);
    @(negedge clk_i);
    code_i = 4'd0; brk_raw_i = lvl;
    edges(1);
  endtask

  initial begin
    rst_ni = 1'b0; dts_tick_i = 1'b1; brk_raw_i = 1'b1; code_i = 4'd5;
    edges(3);
    chk("R7 reset output", brk_filt_o, 1'b0);
    rst_ni = 1'b1;
    brk_raw_i = 1'b0;
    edges(4);
    chk("R7 after release", brk_filt_o, 1'b0);

    // R2: combinational pass-through
    code_i = 4'd0;
    for (int i = 0; i < 4; i++) begin
      brk_raw_i = i[0];
      #1;
      chk("R2 pass-through", brk_filt_o, i[0]);
    end

    // R1 R3 R4 R5: sweep every code, both directions
    for (int c = 1; c < 16; c++) begin
      for (int d = 0; d < 2; d++) begin
        logic old_l;
        int   t;
        old_l = (d == 0) ? 1'b0 : 1'b1;
        t = n_of(c) * div_of(c);
        preload(old_l);
        code_i = 4'(c); brk_raw_i = ~old_l;
        @(posedge clk_i);
        edges(t - 1);
        chk(c <= 3 ? "R3 R1 before N samples" : (c <= 9 ? "R4 R1 before N samples" : "R5 R1 before N samples"),
            brk_filt_o, old_l);
        edges(1);
        chk(c <= 3 ? "R3 R1 at N samples" : (c <= 9 ? "R4 R1 at N samples" : "R5 R1 at N samples"),
            brk_filt_o, ~old_l);
      end
    end

    // R6: a matching sample clears the count (code 2, N=4)
    preload(1'b0);
    code_i = 4'd2; brk_raw_i = 1'b1;
    @(posedge clk_i);
    edges(3);
    brk_raw_i = 1'b0;
    edges(1);
    brk_raw_i = 1'b1;
    edges(3);
    chk("R6 count cleared", brk_filt_o, 1'b0);
    edges(1);
    chk("R6 full run after clear", brk_filt_o, 1'b1);

    // R8: code change mid-count restarts (code 3 then code 2)
    preload(1'b0);
    code_i = 4'd3; brk_raw_i = 1'b1;
    @(posedge clk_i);
    edges(6);
    code_i = 4'd2;
    @(posedge clk_i);
    edges(3);
    chk("R8 restart no carry", brk_filt_o, 1'b0);
    edges(1);
    chk("R8 new count completes", brk_filt_o, 1'b1);

    // R9: no ticks, no sampling (code 13, 32 x 5)
    preload(1'b0);
    dts_tick_i = 1'b0;
    code_i = 4'd13; brk_raw_i = 1'b1;
    @(posedge clk_i);
    edges(300);
    chk("R9 no tick no change", brk_filt_o, 1'b0);
    dts_tick_i = 1'b1;
    edges(159);
    chk("R9 ticks resume before", brk_filt_o, 1'b0);
    edges(1);
    chk("R9 ticks resume at N", brk_filt_o, 1'b1);

    // R10: held level follows raw while bypassed
    preload(1'b1);
    code_i = 4'd7;
    edges(100);
    chk("R10 level kept after bypass", brk_filt_o, 1'b1);
    preload(1'b0);
    code_i = 4'd1;
    edges(20);
    chk("R10 low level kept after bypass", brk_filt_o, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule